// File: doc/BRIEF.md
# Multiprocessor-Addressed UART Transceiver

This block is a full-duplex asynchronous serial transceiver. Each direction has an eight-entry queue. Software-side logic pushes words into the transmit queue and pops received bytes from the receive queue. The block serialises and deserialises the frames on one transmit pin and one receive pin. All timing comes from a single oversampling tick. The tick period is `baud_div + 1` system clocks, and each serial bit lasts sixteen ticks. With `baud_div = 0` and a 16 MHz clock, the line rate is 1 Mbit/s.

A frame is built as follows:

- The line idles high.
- A low start bit comes next.
- The data bits follow, least significant first.
- An optional ninth bit comes after the data.
- A high stop bit ends the frame.

The ninth bit is either a parity bit or, in multiprocessor mode, an address marker. In multiprocessor mode several nodes share one line. A node keeps data frames only after it has seen an address frame carrying its own address. It stops keeping them when an address frame for another node arrives.

The receiver reports four conditions through sticky flags, which stay set until `flags_clr` is pulsed:

- parity mismatch
- a missing stop bit
- a break (the line held low through a whole frame)
- a frame lost to a full receive queue

Top module: `uart_mp`

## Requirements
- R1: Frame timing and layout. One bit lasts 16 ticks of period `baud_div+1` clocks. A frame is a start bit 0, then 8 data bits LSB first, then a ninth bit only when `par_en` or `mp_en` is 1, then a stop bit 1. `txd` is 1 whenever `tx_idle` is 1.
- R2: When `par_en`=1 and `mp_en`=0, the transmitted ninth bit is the XOR of the 8 data bits XOR `par_odd`. So `par_odd`=0 gives even parity and `par_odd`=1 gives odd parity.
- R3: The transmit queue holds 8 words beyond the frame being shifted out. `tx_full` is 1 when it holds 8 words. A push while `tx_full` is 1 is ignored, and that word is never sent.
- R4: The receive queue holds 8 bytes and is first-word fall-through. `rx_data` shows the oldest byte while `rx_empty` is 0, and `rx_pop` removes it. A frame that completes while the queue is full is dropped and sets `err_overrun`.
- R5: With `par_en`=1 and `mp_en`=0, a received ninth bit that differs from the R2 value sets `err_parity`. The byte is still stored.
- R6: A stop bit sampled low sets `err_frame` unless R7 applies. The byte is still stored.
- R7: A frame whose start, data, ninth and stop samples are all low sets `err_break` and stores nothing. No new frame starts until the line has returned high.
- R8: Each received bit is the majority of its samples at oversample ticks 7, 8 and 9. A start bit whose majority is high is treated as noise and yields no frame and no flag.
- R9: With `mp_en`=1, a frame whose ninth bit is 1 is an address frame and is never stored. It selects this node when its byte equals `own_addr` and deselects it otherwise. Frames whose ninth bit is 0 are stored only while the node is selected. The node is deselected after reset.
- R10: With `mp_en`=1, the transmitted ninth bit is `tx_data[8]`.
- R11: The error flags stay set until `flags_clr` is 1. A clear overrides a flag event in the same cycle.
- R12: After reset, `txd`=1, `tx_idle`=1, `tx_full`=0, `rx_empty`=1 and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | 16 | Oversample tick period minus one, in clocks |
| par_en | input | 1 | Enable the parity bit |
| par_odd | input | 1 | Select odd parity (0 selects even) |
| mp_en | input | 1 | Enable 9-bit multiprocessor mode |
| own_addr | input | 8 | Address of this node in multiprocessor mode |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 9 | Byte in [7:0]; address marker in [8] |
| tx_full | output | 1 | Transmit queue is full |
| tx_idle | output | 1 | Transmit queue is empty and the shifter is idle |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue is empty |
| flags_clr | input | 1 | Clear all sticky error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_break | output | 1 | Sticky break detected |
| err_overrun | output | 1 | Sticky receive overflow |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
With `baud_div`=1 a bit lasts 32 clocks. On receive, a byte or flag is due about 9 ticks plus two synchroniser clocks into the stop bit. The bench therefore checks only after it has driven the whole stop bit and an idle bit time. On transmit, each level is held for 32 clocks from the shifter load. The bench samples the line in the middle of each bit, timed from the falling edge of the start bit. A queue pop takes effect one clock later, so `rx_data` is compared on the following falling clock edge.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  // Oversampling ratio and its counter width.
  localparam int unsigned OVS  = 16;
  localparam int unsigned SUBW = $clog2(OVS);

  // One-cycle events raised by the receiver when a frame ends.
  typedef struct packed {
    logic par;
    logic frm;
    logic brk;
  } rx_evt_t;
endpackage

// File: rtl/uart_mp_fifo.sv
module uart_mp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign dout  = mem[rptr[AW-1:0]];

  // Storage has no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
  import uart_mp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          avail,
  input  logic [DW-1:0] data,
  input  logic          nine,
  input  logic          ninth,
  output logic          pop,
  output logic          busy,
  output logic          txd
);
  localparam int FW = DW + 3;
  localparam int BW = $clog2(FW + 1);
  localparam logic [SUBW-1:0] SUB_END = SUBW'(OVS - 1);

  logic [FW-1:0]   sh;
  logic [BW-1:0]   idx, last;
  logic [SUBW-1:0] sub;

  assign pop = !busy && avail;
  assign txd = !busy || sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sub  <= '0;
      idx  <= '0;
      last <= '0;
      sh   <= '1;
    end else if (pop) begin
      sh   <= {1'b1, (nine ? ninth : 1'b1), data, 1'b0};
      last <= nine ? BW'(DW + 2) : BW'(DW + 1);
      idx  <= '0;
      sub  <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (sub == SUB_END) begin
        sub <= '0;
        sh  <= {1'b1, sh[FW-1:1]};
        if (idx == last) busy <= 1'b0;
        else             idx  <= idx + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_s,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          mp_en,
  input  logic [DW-1:0] own_addr,
  output logic          push,
  output logic [DW-1:0] pdata,
  output rx_evt_t       evt
);
  localparam int BW = $clog2(DW + 3);
  localparam logic [SUBW-1:0] S_A   = SUBW'(OVS / 2 - 1);
  localparam logic [SUBW-1:0] S_B   = SUBW'(OVS / 2);
  localparam logic [SUBW-1:0] S_C   = SUBW'(OVS / 2 + 1);
  localparam logic [SUBW-1:0] S_END = SUBW'(OVS - 1);

  logic            active, armed, sel, allz, s_a, s_b;
  logic [SUBW-1:0] sub;
  logic [BW-1:0]   bitn, last;
  logic [DW:0]     sh;
  logic            nine, maj, ninth_v;
  logic [DW-1:0]   data_v;

  assign nine    = par_en || mp_en;
  assign last    = nine ? BW'(DW + 2) : BW'(DW + 1);
  assign maj     = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
  assign ninth_v = sh[DW];
  assign data_v  = nine ? sh[DW-1:0] : sh[DW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      armed  <= 1'b0;
      sel    <= 1'b0;
      allz   <= 1'b0;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      sub    <= '0;
      bitn   <= '0;
      sh     <= '0;
      push   <= 1'b0;
      pdata  <= '0;
      evt    <= '0;
    end else begin
      push <= 1'b0;
      evt  <= '0;
      if (!active) begin
        if (rx_s) armed <= 1'b1;
        if (tick && armed && !rx_s) begin
          active <= 1'b1;
          sub    <= '0;
          bitn   <= '0;
          allz   <= 1'b1;
        end
      end else if (tick) begin
        sub <= (sub == S_END) ? '0 : sub + 1'b1;
        if (sub == S_END) bitn <= bitn + 1'b1;
        if (sub == S_A) s_a <= rx_s;
        if (sub == S_B) s_b <= rx_s;
        if (sub == S_C) begin
          if (bitn == '0) begin
            if (maj) active <= 1'b0;          // noise, not a start bit
          end else if (bitn == last) begin
            active <= 1'b0;
            armed  <= 1'b0;
            if (allz && !maj) begin
              evt.brk <= 1'b1;
            end else begin
              evt.frm <= !maj;
              evt.par <= par_en && !mp_en && (ninth_v != ((^data_v) ^ par_odd));
              pdata   <= data_v;
              if (!mp_en)        push <= 1'b1;
              else if (ninth_v)  sel  <= (data_v == own_addr);
              else               push <= sel;
            end
          end else begin
            sh   <= {maj, sh[DW:1]};
            allz <= allz & !maj;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_mp.sv
module uart_mp
  import uart_mp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int DIVW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] baud_div,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            mp_en,
  input  logic [DW-1:0]   own_addr,
  input  logic            tx_push,
  input  logic [DW:0]     tx_data,
  output logic            tx_full,
  output logic            tx_idle,
  input  logic            rx_pop,
  output logic [DW-1:0]   rx_data,
  output logic            rx_empty,
  input  logic            flags_clr,
  output logic            err_parity,
  output logic            err_frame,
  output logic            err_break,
  output logic            err_overrun,
  input  logic            rxd,
  output logic            txd
);
  logic [DIVW-1:0] div_cnt;
  logic            tick;
  logic [1:0]      rx_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
      rx_sync <= 2'b11;
    end else begin
      tick    <= (div_cnt == baud_div);
      div_cnt <= (div_cnt == baud_div) ? '0 : div_cnt + 1'b1;
      rx_sync <= {rx_sync[0], rxd};
    end
  end

  // Transmit path
  logic [DW:0] txq_head;
  logic        txq_empty, tx_pop, tx_busy, tx_ninth;

  uart_mp_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(tx_data), .pop(tx_pop),
    .dout(txq_head), .full(tx_full), .empty(txq_empty)
  );

  assign tx_ninth = mp_en ? txq_head[DW] : ((^txq_head[DW-1:0]) ^ par_odd);
  assign tx_idle  = txq_empty && !tx_busy;

  uart_mp_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .avail(!txq_empty),
    .data(txq_head[DW-1:0]), .nine(par_en || mp_en), .ninth(tx_ninth),
    .pop(tx_pop), .busy(tx_busy), .txd(txd)
  );

  // Receive path
  logic          rx_push, rxq_full;
  logic [DW-1:0] rx_pdata;
  rx_evt_t       rx_evt;

  uart_mp_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx_s(rx_sync[1]),
    .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en), .own_addr(own_addr),
    .push(rx_push), .pdata(rx_pdata), .evt(rx_evt)
  );

  uart_mp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_pdata), .pop(rx_pop),
    .dout(rx_data), .full(rxq_full), .empty(rx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst || flags_clr) begin
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_break   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      err_parity  <= err_parity  | rx_evt.par;
      err_frame   <= err_frame   | rx_evt.frm;
      err_break   <= err_break   | rx_evt.brk;
      err_overrun <= err_overrun | (rx_push && rxq_full);
    end
  end
endmodule

// File: rtl/uart_mp_chk.sv
module uart_mp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          txd,
  input logic          tx_idle,
  input logic          tx_full,
  input logic          rx_pop,
  input logic          rx_empty,
  input logic [DW-1:0] rx_data,
  input logic          flags_clr,
  input logic          err_parity,
  input logic          err_frame,
  input logic          err_break,
  input logic          err_overrun
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> txd);

  a_r3_full_busy: assert property (@(posedge clk) disable iff (rst)
    tx_full |-> !tx_idle);

  a_r4_head_hold: assert property (@(posedge clk) disable iff (rst)
    (!rx_empty && !rx_pop) |=> (!rx_empty && $stable(rx_data)));

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !flags_clr) |=> err_overrun);

  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    flags_clr |=> !(err_parity || err_frame || err_break || err_overrun));
endmodule

bind uart_mp uart_mp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .txd(txd), .tx_idle(tx_idle), .tx_full(tx_full),
  .rx_pop(rx_pop), .rx_empty(rx_empty), .rx_data(rx_data),
  .flags_clr(flags_clr), .err_parity(err_parity), .err_frame(err_frame),
  .err_break(err_break), .err_overrun(err_overrun)
);

// File: tb/tb_uart_mp.sv
`timescale 1ns/1ps
module tb_uart_mp;
  localparam int BT = 32;   // 16 ticks x (baud_div+1 = 2) clocks

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] baud_div = 16'd1;
  logic        par_en = 1'b0, par_odd = 1'b0, mp_en = 1'b0;
  logic [7:0]  own_addr = 8'h42;
  logic        tx_push = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_full, tx_idle, rx_empty, txd;
  logic        rx_pop = 1'b0, flags_clr = 1'b0, rxd = 1'b1;
  logic [7:0]  rx_data;
  logic        err_parity, err_frame, err_break, err_overrun;

  int total = 0;
  int bad   = 0;

  uart_mp dut (
    .clk(clk), .rst(rst), .baud_div(baud_div), .par_en(par_en), .par_odd(par_odd),
    .mp_en(mp_en), .own_addr(own_addr), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_idle(tx_idle), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_empty(rx_empty), .flags_clr(flags_clr), .err_parity(err_parity),
    .err_frame(err_frame), .err_break(err_break), .err_overrun(err_overrun),
    .rxd(rxd), .txd(txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    flags_clr = 1'b1; wait_clk(1); flags_clr = 1'b0; wait_clk(1);
  endtask

  task automatic rx_send(input logic [7:0] d, input bit has9, input bit b9, input bit stopv);
    rxd = 1'b0; wait_clk(BT);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_clk(BT); end
    if (has9) begin rxd = b9; wait_clk(BT); end
    rxd = stopv; wait_clk(BT);
    rxd = 1'b1; wait_clk(BT);
  endtask

  task automatic pop_check(input logic [7:0] exp, input string req);
    check(!rx_empty, req, rx_empty, 0);
    check(rx_data == exp, req, rx_data, exp);
    rx_pop = 1'b1; wait_clk(1); rx_pop = 1'b0;
  endtask

  task automatic push_tx(input logic [8:0] d);
    tx_push = 1'b1; tx_data = d; wait_clk(1); tx_push = 1'b0;
  endtask

  task automatic tx_cap(input int nb, output logic [10:0] b);
    int guard = 0;
    b = '1;
    while (txd !== 1'b0 && guard < 2000) begin wait_clk(1); guard++; end
    wait_clk(BT / 2);
    for (int i = 0; i < nb; i++) begin
      b[i] = txd;
      if (i < nb - 1) wait_clk(BT);
    end
  endtask

  task automatic t_reset();
    check(txd == 1'b1, "R12 txd", txd, 1);
    check(tx_idle == 1'b1 && tx_full == 1'b0, "R12 tx status", {tx_idle, tx_full}, 2);
    check(rx_empty == 1'b1, "R12 rx_empty", rx_empty, 1);
    check({err_parity, err_frame, err_break, err_overrun} == 4'b0, "R12 flags",
          {err_parity, err_frame, err_break, err_overrun}, 0);
  endtask

  task automatic t_tx_basic();
    logic [10:0] b;
    push_tx(9'h0A5);
    tx_cap(10, b);
    check(b[0] == 1'b0 && b[9] == 1'b1, "R1 start/stop", {b[9], b[0]}, 2);
    check(b[8:1] == 8'hA5, "R1 tx data", b[8:1], 8'hA5);
    wait_clk(BT);
    check(tx_idle && txd, "R1 idle after frame", {tx_idle, txd}, 3);
  endtask

  task automatic t_tx_parity();
    logic [10:0] b;
    par_en = 1'b1; par_odd = 1'b0;
    push_tx(9'h007);
    tx_cap(11, b);
    check(b[8:1] == 8'h07 && b[9] == 1'b1 && b[10] == 1'b1, "R2 even parity", b, 11'h60E);
    wait_clk(BT);
    par_odd = 1'b1;
    push_tx(9'h007);
    tx_cap(11, b);
    check(b[9] == 1'b0 && b[10] == 1'b1, "R2 odd parity", b[10:9], 2);
    wait_clk(BT);
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_tx_fill();
    logic [10:0] b;
    logic [7:0] exp [9];
    for (int i = 0; i < 9; i++) begin
      exp[i] = 8'(8'h30 + i);
      push_tx({1'b0, exp[i]});
    end
    check(tx_full == 1'b1, "R3 full after 9 pushes", tx_full, 1);
    push_tx(9'h0EE);
    for (int i = 0; i < 9; i++) begin
      tx_cap(10, b);
      check(b[8:1] == exp[i], "R3 queue order", b[8:1], exp[i]);
    end
    wait_clk(2 * BT);
    check(tx_idle == 1'b1, "R3 push while full ignored", tx_idle, 1);
  endtask

  task automatic t_tx_mp();
    logic [10:0] b;
    mp_en = 1'b1;
    push_tx(9'h142);
    tx_cap(11, b);
    check(b[8:1] == 8'h42 && b[9] == 1'b1, "R10 address mark", b[9:1], 9'h142);
    wait_clk(BT);
    push_tx(9'h081);
    tx_cap(11, b);
    check(b[9] == 1'b0, "R10 data mark", b[9], 0);
    wait_clk(BT);
    mp_en = 1'b0;
  endtask

  task automatic t_rx_basic();
    rx_send(8'h3C, 0, 0, 1);
    pop_check(8'h3C, "R1 rx byte");
    wait_clk(1);
    check(rx_empty == 1'b1, "R4 empty after pop", rx_empty, 1);
    check(!err_frame && !err_parity, "R1 no error", {err_frame, err_parity}, 0);
  endtask

  task automatic t_rx_parity();
    par_en = 1'b1;
    rx_send(8'h07, 1, 1, 1);
    check(err_parity == 1'b0, "R5 good parity", err_parity, 0);
    pop_check(8'h07, "R5 good byte");
    rx_send(8'h07, 1, 0, 1);
    check(err_parity == 1'b1, "R5 bad parity flagged", err_parity, 1);
    pop_check(8'h07, "R5 byte kept");
    wait_clk(2 * BT);
    check(err_parity == 1'b1, "R11 parity sticky", err_parity, 1);
    clear_flags();
    check(err_parity == 1'b0, "R11 cleared", err_parity, 0);
    par_en = 1'b0;
  endtask

  task automatic t_rx_frame();
    rx_send(8'h81, 0, 0, 0);
    check(err_frame == 1'b1 && err_break == 1'b0, "R6 framing", {err_frame, err_break}, 2);
    pop_check(8'h81, "R6 byte kept");
    clear_flags();
  endtask

  task automatic t_rx_break();
    rxd = 1'b0; wait_clk(12 * BT);
    rxd = 1'b1; wait_clk(2 * BT);
    check(err_break == 1'b1, "R7 break flagged", err_break, 1);
    check(rx_empty == 1'b1, "R7 nothing stored", rx_empty, 1);
    check(err_frame == 1'b0, "R7 not framing", err_frame, 0);
    clear_flags();
    rx_send(8'h5A, 0, 0, 1);
    pop_check(8'h5A, "R7 recovery");
  endtask

  task automatic t_rx_glitch();
    rxd = 1'b0; wait_clk(4);
    rxd = 1'b1; wait_clk(12 * BT);
    check(rx_empty == 1'b1, "R8 glitch rejected", rx_empty, 1);
    check({err_frame, err_break} == 2'b0, "R8 no flags", {err_frame, err_break}, 0);
  endtask

  task automatic t_rx_overflow();
    for (int i = 0; i < 9; i++) rx_send(8'(8'hA0 + i), 0, 0, 1);
    check(err_overrun == 1'b1, "R4 overrun flagged", err_overrun, 1);
    for (int i = 0; i < 8; i++) begin
      pop_check(8'(8'hA0 + i), "R4 stored order");
      wait_clk(1);
    end
    check(rx_empty == 1'b1, "R4 ninth frame dropped", rx_empty, 1);
    check(err_overrun == 1'b1, "R11 overrun sticky", err_overrun, 1);
    clear_flags();
    check(err_overrun == 1'b0, "R11 overrun cleared", err_overrun, 0);
  endtask

  task automatic t_rx_mp();
    mp_en = 1'b1;
    rx_send(8'h11, 1, 0, 1);
    check(rx_empty == 1'b1, "R9 data before address dropped", rx_empty, 1);
    rx_send(8'h42, 1, 1, 1);
    check(rx_empty == 1'b1, "R9 address not stored", rx_empty, 1);
    rx_send(8'h22, 1, 0, 1);
    rx_send(8'h43, 1, 1, 1);
    rx_send(8'h33, 1, 0, 1);
    pop_check(8'h22, "R9 selected data");
    wait_clk(1);
    check(rx_empty == 1'b1, "R9 deselected data dropped", rx_empty, 1);
    check(err_parity == 1'b0, "R9 no parity check", err_parity, 0);
    mp_en = 1'b0;
  endtask

  task automatic run_all();
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    t_reset();
    t_tx_basic();
    t_tx_parity();
    t_tx_fill();
    t_tx_mp();
    wait_clk(2 * BT);
    t_rx_basic();
    t_rx_parity();
    t_rx_frame();
    t_rx_break();
    t_rx_glitch();
    t_rx_overflow();
    t_rx_mp();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule